// File: doc/BRIEF.md
# Transceiver Frame Store

This block is the byte store that sits between a processor and a short-range radio. It holds one frame of up to 128 bytes. The frame is either captured by the receiver or staged by software for the transmitter. Two ports reach the store, and both can be used in the same cycle. The processor port decodes a fixed 128-byte window of the I/O address space and gives random byte access. The radio port lets the receiver write bytes and the transmitter fetch bytes by index.

Processor access depends on the transceiver's power and sleep condition. While the radio is powered down or asleep, reads return zero and writes are discarded. A frame-valid flag shows whether the stored bytes still describe a complete frame. The flag is cleared by:
- sleep,
- a transceiver reset,
- a system reset,
- power-down,
- the start of a new reception.

Incoming bytes are not blocked while software reads an older frame. A sticky overwrite flag records that this happened, so software can throw away what it read.

Top module: `fbuf_frame_store`

## Requirements
- R1: The processor port responds only to addresses 0x180 through 0x1FF, with byte index equal to address minus 0x180. `cpu_hit` is high only inside that window. An access outside it does not touch the store, and a read there returns 0x00.
- R2: An accepted processor write stores the byte at the next edge. An accepted processor read presents the stored byte on `cpu_rdata` one cycle after the request.
- R3: When `pwr_down` is high or `trx_state` is SLEEP (code 1), a processor read returns 0x00 and a processor write is dropped.
- R4: A radio write is performed only while `trx_state` is RX_BUSY (code 4). In every other state, including PLL_ON (code 2), it is ignored.
- R5: A radio read presents the indexed byte on `rad_rdata` one cycle later and holds it while `rad_re` is low. It works in the same cycle as a processor access.
- R6: When both ports write the same index in the same cycle, the radio byte is the one stored.
- R7: `frame_valid` rises after an `rx_end` pulse, or after an accepted processor write to address 0x180.
- R8: `frame_valid` is low after system reset, and it is cleared by sleep, `trx_rst` or `pwr_down`. A clear in the same cycle as a set wins.
- R9: The first cycle of RX_BUSY after any other state clears `frame_valid`.
- R10: An accepted processor read while `frame_valid` is high opens a read session. An accepted radio write during a session sets the sticky `ovr_flag`. `ovr_ack` clears both the flag and the session.
- R11: After reset, `cpu_rdata`, `rad_rdata`, `frame_valid` and `ovr_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| trx_rst | input | 1 | Transceiver reset pulse |
| pwr_down | input | 1 | Transceiver power-reduction request |
| trx_state | input | 3 | Transceiver state: 0 OFF, 1 SLEEP, 2 PLL_ON, 3 RX_ON, 4 RX_BUSY, 5 TX_BUSY |
| cpu_addr | input | 9 | Processor I/O address |
| cpu_rd | input | 1 | Processor read request |
| cpu_wr | input | 1 | Processor write request |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rdata | output | 8 | Processor read byte, one cycle after request |
| cpu_hit | output | 1 | Address lies inside the store window |
| ovr_ack | input | 1 | Clears the overwrite flag and the read session |
| rad_we | input | 1 | Radio write strobe |
| rad_re | input | 1 | Radio read strobe |
| rad_idx | input | 7 | Radio byte index |
| rad_wdata | input | 8 | Radio write byte |
| rad_rdata | output | 8 | Radio read byte, one cycle after request |
| rx_end | input | 1 | End-of-reception pulse |
| frame_valid | output | 1 | Stored frame is valid |
| ovr_flag | output | 1 | Sticky: radio overwrote during a processor read session |

## Verification
The embedded properties assume that `trx_state` carries only the six listed codes and that `rx_end` and the strobes are sampled at clock edges. They make no assumption about how these inputs relate to each other, so clears and sets can collide freely. The stimulus changes every input one time unit after a rising edge and moves `trx_state` only between legal codes. Collisions that the properties have to tolerate, such as `rx_end` together with `pwr_down`, are driven on purpose.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;
   typedef enum logic [2:0] {
      TRX_OFF     = 3'd0,
      TRX_SLEEP   = 3'd1,
      TRX_PLL     = 3'd2,
      TRX_RX_ON   = 3'd3,
      TRX_RX_BUSY = 3'd4,
      TRX_TX_BUSY = 3'd5
   } trx_mode_e;
endpackage

// File: rtl/fbuf_cpu_port.sv
module fbuf_cpu_port #(
   parameter int ADDR_W = 9,
   parameter int IDX_W  = 7,
   parameter int BASE   = 'h180
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   input  logic              blocked,
   output logic              hit,
   output logic              rd_ok,
   output logic              wr_ok,
   output logic              first_wr,
   output logic [IDX_W-1:0]  idx
);
   localparam int DEPTH = 1 << IDX_W;
   logic in_win;

   generate
      if ((BASE % DEPTH) == 0) begin : g_aligned
         localparam logic [ADDR_W-IDX_W-1:0] BASE_HI = (ADDR_W-IDX_W)'(BASE >> IDX_W);
         assign in_win = (addr[ADDR_W-1:IDX_W] == BASE_HI);
         assign idx    = addr[IDX_W-1:0];
      end else begin : g_offset
         localparam logic [ADDR_W:0] BASE_V = (ADDR_W+1)'(BASE);
         localparam logic [ADDR_W:0] END_V  = (ADDR_W+1)'(BASE + DEPTH);
         logic [ADDR_W:0] off;
         assign off    = {1'b0, addr} - BASE_V;
         assign in_win = ({1'b0, addr} >= BASE_V) && ({1'b0, addr} < END_V);
         assign idx    = off[IDX_W-1:0];
      end
   endgenerate

   assign hit      = in_win;
   assign rd_ok    = rd && in_win && !blocked;
   assign wr_ok    = wr && in_win && !blocked;
   assign first_wr = wr_ok && (idx == '0);
endmodule

// File: rtl/fbuf_mem.sv
module fbuf_mem #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_we,
   input  logic              cpu_re,
   input  logic [IDX_W-1:0]  cpu_idx,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              rad_we,
   input  logic              rad_re,
   input  logic [IDX_W-1:0]  rad_idx,
   input  logic [DATA_W-1:0] rad_wdata,
   output logic [DATA_W-1:0] rad_rdata
);
   localparam int DEPTH = 1 << IDX_W;
   logic [DATA_W-1:0] store [DEPTH];

   // Radio write placed last: on an index collision it lands (R6).
   always_ff @(posedge clk) begin
      if (cpu_we) store[cpu_idx] <= cpu_wdata;
      if (rad_we) store[rad_idx] <= rad_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_rdata <= '0;
         rad_rdata <= '0;
      end else begin
         cpu_rdata <= cpu_re ? store[cpu_idx] : '0;
         if (rad_re) rad_rdata <= store[rad_idx];
      end
   end

   assert_rad_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rad_re |=> $stable(rad_rdata));
endmodule

// File: rtl/fbuf_status.sv
module fbuf_status (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       trx_rst,
   input  logic       pwr_down,
   input  logic       sleeping,
   input  logic       rx_busy,
   input  logic       rx_end,
   input  logic       first_wr,
   input  logic       cpu_rd_ok,
   input  logic       rad_wr_ok,
   input  logic       ack,
   output logic       frame_valid,
   output logic       ovr_flag
);
   logic busy_q, session_q, kill;

   assign kill = sleeping || trx_rst || pwr_down || (rx_busy && !busy_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         frame_valid <= 1'b0;
         session_q   <= 1'b0;
         ovr_flag    <= 1'b0;
      end else begin
         busy_q <= rx_busy;
         if (kill)                     frame_valid <= 1'b0;
         else if (rx_end || first_wr)  frame_valid <= 1'b1;
         if (ack) begin
            session_q <= 1'b0;
            ovr_flag  <= 1'b0;
         end else begin
            if (cpu_rd_ok && frame_valid) session_q <= 1'b1;
            if (rad_wr_ok && session_q)   ovr_flag  <= 1'b1;
         end
      end
   end

   assert_valid_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sleeping || trx_rst || pwr_down) |=> !frame_valid);
   assert_rx_entry_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_busy) |=> !frame_valid);
   assert_valid_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_valid) |-> $past(rx_end || first_wr));
   assert_ovr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_flag && !ack) |=> ovr_flag);
   assert_ovr_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ovr_flag);
endmodule

// File: rtl/fbuf_frame_store.sv
module fbuf_frame_store #(
   parameter int ADDR_W = 9,
   parameter int IDX_W  = 7,
   parameter int DATA_W = 8,
   parameter int BASE   = 'h180
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trx_rst,
   input  logic              pwr_down,
   input  logic [2:0]        trx_state,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_hit,
   input  logic              ovr_ack,
   input  logic              rad_we,
   input  logic              rad_re,
   input  logic [IDX_W-1:0]  rad_idx,
   input  logic [DATA_W-1:0] rad_wdata,
   output logic [DATA_W-1:0] rad_rdata,
   input  logic              rx_end,
   output logic              frame_valid,
   output logic              ovr_flag
);
   import fbuf_pkg::*;
   localparam int DEPTH = 1 << IDX_W;

   generate
      if (BASE + DEPTH > (1 << ADDR_W)) begin : g_bad_window
         $error("store window exceeds address space");
      end
      if (IDX_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("index and data widths must be positive");
      end
   endgenerate

   logic sleeping, rx_busy, blocked;
   logic rd_ok, wr_ok, first_wr, rad_wr_ok;
   logic [IDX_W-1:0] cpu_idx;

   assign sleeping  = (trx_state == TRX_SLEEP);
   assign rx_busy   = (trx_state == TRX_RX_BUSY);
   assign blocked   = pwr_down || sleeping;
   assign rad_wr_ok = rad_we && rx_busy;

   fbuf_cpu_port #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE(BASE)) u_port (
      .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr), .blocked(blocked),
      .hit(cpu_hit), .rd_ok(rd_ok), .wr_ok(wr_ok), .first_wr(first_wr),
      .idx(cpu_idx));

   fbuf_mem #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .cpu_we(wr_ok), .cpu_re(rd_ok), .cpu_idx(cpu_idx),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .rad_we(rad_wr_ok), .rad_re(rad_re), .rad_idx(rad_idx),
      .rad_wdata(rad_wdata), .rad_rdata(rad_rdata));

   fbuf_status u_stat (
      .clk(clk), .rst_n(rst_n), .trx_rst(trx_rst), .pwr_down(pwr_down),
      .sleeping(sleeping), .rx_busy(rx_busy), .rx_end(rx_end),
      .first_wr(first_wr), .cpu_rd_ok(rd_ok), .rad_wr_ok(rad_wr_ok),
      .ack(ovr_ack), .frame_valid(frame_valid), .ovr_flag(ovr_flag));

   assert_refused_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && (pwr_down || trx_state == 3'd1)) |=> (cpu_rdata == '0));
   assert_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cpu_addr) < BASE) |-> !cpu_hit);
   assert_outside_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && !cpu_hit) |=> (cpu_rdata == '0));
endmodule

// File: tb/fbuf_frame_store_test.sv
module fbuf_frame_store_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       trx_rst = 1'b0, pwr_down = 1'b0;
   logic [2:0] trx_state = 3'd2;
   logic [8:0] cpu_addr = '0;
   logic       cpu_rd = 1'b0, cpu_wr = 1'b0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] cpu_rdata;
   logic       cpu_hit;
   logic       ovr_ack = 1'b0;
   logic       rad_we = 1'b0, rad_re = 1'b0;
   logic [6:0] rad_idx = '0;
   logic [7:0] rad_wdata = '0;
   logic [7:0] rad_rdata;
   logic       rx_end = 1'b0;
   logic       frame_valid, ovr_flag;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [7:0] rv;

   localparam logic [2:0] ST_SLEEP = 3'd1, ST_PLL = 3'd2, ST_BUSY = 3'd4;

   always #10 clk = ~clk;

   fbuf_frame_store uut (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic cpu_write(input logic [8:0] a, input logic [7:0] d);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
      tick();
      cpu_wr = 1'b0;
   endtask

   task automatic cpu_read(input logic [8:0] a, output logic [7:0] d);
      cpu_addr = a; cpu_rd = 1'b1;
      tick();
      cpu_rd = 1'b0;
      d = cpu_rdata;
   endtask

   task automatic rad_write(input logic [6:0] i, input logic [7:0] d);
      rad_idx = i; rad_wdata = d; rad_we = 1'b1;
      tick();
      rad_we = 1'b0;
   endtask

   task automatic pulse_rx_end();
      rx_end = 1'b1; tick(); rx_end = 1'b0;
   endtask

   task automatic t_reset();
      chk("R11 cpu_rdata", cpu_rdata, 0);
      chk("R11 rad_rdata", rad_rdata, 0);
      chk("R11 frame_valid", frame_valid, 0);
      chk("R11 ovr_flag", ovr_flag, 0);
   endtask

   task automatic t_cpu_rw();
      trx_state = ST_PLL;
      cpu_write(9'h185, 8'hA5);
      chk("R7 non-first write keeps invalid", frame_valid, 0);
      cpu_write(9'h1FF, 8'h3C);
      cpu_read(9'h185, rv); chk("R2 read 0x185", rv, 8'hA5);
      cpu_read(9'h1FF, rv); chk("R2 read 0x1FF", rv, 8'h3C);
      cpu_addr = 9'h17F; #1 chk("R1 hit below window", cpu_hit, 0);
      cpu_addr = 9'h180; #1 chk("R1 hit at base", cpu_hit, 1);
      cpu_write(9'h17F, 8'h77);
      cpu_write(9'h0FF, 8'h66);
      cpu_read(9'h1FF, rv); chk("R1 outside write no alias", rv, 8'h3C);
      cpu_read(9'h17F, rv); chk("R1 outside read zero", rv, 0);
   endtask

   task automatic t_gate();
      trx_state = ST_SLEEP;
      cpu_read(9'h185, rv); chk("R3 sleep read zero", rv, 0);
      cpu_write(9'h185, 8'h11);
      trx_state = ST_PLL;
      pwr_down = 1'b1;
      cpu_read(9'h185, rv); chk("R3 pwr_down read zero", rv, 0);
      cpu_write(9'h1FF, 8'h22);
      pwr_down = 1'b0;
      cpu_read(9'h185, rv); chk("R3 sleep write dropped", rv, 8'hA5);
      cpu_read(9'h1FF, rv); chk("R3 pwr_down write dropped", rv, 8'h3C);
   endtask

   task automatic t_valid();
      trx_state = ST_PLL;
      cpu_write(9'h180, 8'h0F);
      chk("R7 first byte sets valid", frame_valid, 1);
      trx_state = ST_SLEEP; tick(); trx_state = ST_PLL;
      chk("R8 sleep clears valid", frame_valid, 0);
      pulse_rx_end();
      chk("R7 rx_end sets valid", frame_valid, 1);
      trx_rst = 1'b1; tick(); trx_rst = 1'b0;
      chk("R8 trx_rst clears valid", frame_valid, 0);
      pulse_rx_end();
      pwr_down = 1'b1; tick(); pwr_down = 1'b0;
      chk("R8 pwr_down clears valid", frame_valid, 0);
      pwr_down = 1'b1; rx_end = 1'b1; tick(); pwr_down = 1'b0; rx_end = 1'b0;
      chk("R8 clear beats set", frame_valid, 0);
   endtask

   task automatic t_radio();
      trx_state = ST_PLL;
      pulse_rx_end();
      trx_state = ST_BUSY; tick();
      chk("R9 rx entry clears valid", frame_valid, 0);
      rad_write(7'd5, 8'hC3);
      rad_idx = 7'd5; rad_re = 1'b1;
      cpu_addr = 9'h1FF; cpu_rd = 1'b1;
      tick();
      rad_re = 1'b0; cpu_rd = 1'b0;
      chk("R5 radio read", rad_rdata, 8'hC3);
      chk("R5 concurrent cpu read", cpu_rdata, 8'h3C);
      rad_idx = 7'd20; tick();
      chk("R5 radio data held", rad_rdata, 8'hC3);
      cpu_read(9'h185, rv); chk("R5 cpu sees radio byte", rv, 8'hC3);
      trx_state = ST_PLL;
      rad_write(7'd5, 8'h00);
      cpu_read(9'h185, rv); chk("R4 pll_on radio write ignored", rv, 8'hC3);
      trx_state = ST_BUSY;
      cpu_addr = 9'h190; cpu_wdata = 8'hAA; cpu_wr = 1'b1;
      rad_idx = 7'h10; rad_wdata = 8'h55; rad_we = 1'b1;
      tick();
      cpu_wr = 1'b0; rad_we = 1'b0;
      cpu_read(9'h190, rv); chk("R6 radio wins collision", rv, 8'h55);
   endtask

   task automatic t_ovr();
      trx_state = ST_PLL;
      pulse_rx_end();
      rad_write(7'd3, 8'h99);
      chk("R10 no session no flag", ovr_flag, 0);
      cpu_read(9'h185, rv);
      trx_state = ST_BUSY; tick();
      rad_write(7'd3, 8'h44);
      chk("R10 overwrite sets flag", ovr_flag, 1);
      tick();
      chk("R10 flag sticky", ovr_flag, 1);
      ovr_ack = 1'b1; tick(); ovr_ack = 1'b0;
      chk("R10 ack clears flag", ovr_flag, 0);
      rad_write(7'd3, 8'h45);
      chk("R10 ack closes session", ovr_flag, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_cpu_rw();
      t_gate();
      t_valid();
      t_radio();
      t_ovr();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog R11 actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule